// File: doc/BRIEF.md
# Two-Wire Serial Target Byte Engine

This block is the target side of a two-wire serial bus. It watches the clock and data lines through a synchroniser that runs on a fast system clock. It recognises START, repeated START and STOP conditions, then shifts in an address packet and decides whether to answer it. After answering, it either receives bytes from the controller or sends bytes to it. The pads are open-drain. The block models this with a single output-enable, `sda_oe`: a 1 pulls the data line low, and a 0 releases it so the line floats high.

The local side is a small set of plain signals:

- **Configuration:** `own_addr` sets the block's own 7-bit address, and `gc_en` enables general-call acceptance.
- **Back-pressure:** `busy` refuses the current packet.
- **Transmit:** `tx_data` holds the next byte to send. `tx_load` marks the cycle in which that byte is taken.
- **Receive:** `rx_data` and `rx_valid` hand over each acknowledged received byte.
- **Status:** `sel`, `dir_rd`, `gen_call` and `ctl_nack` report the state of the current transfer.

The controller role, clock stretching, arbitration and 10-bit addressing are not part of this block.

Top module: `tws_target`

## Requirements
- R1: After synchronous reset, `sda_oe`, `sel`, `rx_valid` and `tx_load` are 0.
- R2: A falling data line while the clock is high (START) restarts address reception at any point, and a partially received byte is discarded. A rising data line while the clock is high (STOP) ends the transfer: in the next cycle `sda_oe` and `sel` are 0.
- R3: An address packet is 7 address bits, most significant first, then a direction bit captured on rising clock edges. A match with `own_addr` is acknowledged by holding `sda_oe`=1 through the ninth clock, and `sel` goes to 1. A non-matching address leaves the line released.
- R4: In a write transfer (direction bit 0), each byte is shifted in most-significant bit first. It is presented on `rx_data` with a one-cycle `rx_valid` pulse and acknowledged on the ninth clock.
- R5: In a read transfer (direction bit 1), `tx_data` is taken (`tx_load` pulses for one cycle) after the address acknowledge and after each controller ACK. It is sent most-significant bit first, where `sda_oe`=1 sends a 0 bit.
- R6: When the controller NACKs a transmitted byte, `ctl_nack` pulses. The target releases the data line, drops `sel`, and sends nothing more until the next START.
- R7: Address 0000000 with direction bit 0 is a general call. When `gc_en`=1 it is acknowledged, `gen_call` reads 1, and the following bytes are received. When `gc_en`=0 it is not acknowledged.
- R8: Address 0000000 with direction bit 1 is never acknowledged, and no data is driven afterwards.
- R9: Addresses whose top four bits are 1111 are never acknowledged, even when `own_addr` holds that value.
- R10: If `busy`=1 when an acknowledge slot begins, the target NACKs, and for a data byte does not report it. It then stays silent until the next START.
- R11: `sda_oe` is only raised while the synchronised clock is low, so the target never creates a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Own target address |
| gc_en | input | 1 | Accept general call |
| busy | input | 1 | Force NACK at the next acknowledge slot |
| tx_data | input | 8 | Next byte to transmit |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is taken |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse with a new `rx_data` |
| sel | output | 1 | Target is addressed and taking part |
| dir_rd | output | 1 | Current transfer is a read |
| gen_call | output | 1 | Current transfer is a general call |
| ctl_nack | output | 1 | One-cycle pulse when the controller NACKs |

## Verification
The assertions assume a well-behaved controller:

- The data line changes only while the clock is low, except for deliberate START and STOP conditions.
- Each line level is held for longer than the synchroniser delay plus one edge-detect cycle.
- `busy` and `gc_en` are steady around an acknowledge slot.

The stimulus meets these assumptions. It drives the bus in quarter-bit steps of eight system clocks, changes data one quarter before each rising clock edge, and changes configuration only while the bus is idle or the clock is low.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int RSVD_W = 4;
    localparam logic [RSVD_W-1:0] RSVD_TAG = '1;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_AWAIT, S_AACK,
        S_RX, S_RWAIT, S_RACK,
        S_TX, S_TACK, S_TDONE
    } st_t;

    typedef struct packed {
        logic ack;
        logic gc;
        logic rd;
    } match_t;

    function automatic logic is_reserved(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: RSVD_W] == RSVD_TAG;
    endfunction
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_ff[i] <= 1'b1;
                        sda_ff[i] <= 1'b1;
                    end else begin
                        scl_ff[i] <= scl_i;
                        sda_ff[i] <= sda_i;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        scl_ff[i] <= 1'b1;
                        sda_ff[i] <= 1'b1;
                    end else begin
                        scl_ff[i] <= scl_ff[i-1];
                        sda_ff[i] <= sda_ff[i-1];
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

    // R2: bus events are mutually exclusive in any cycle
    p_events_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_c, stop_c, scl_rise, scl_fall}));
endmodule

// File: rtl/tws_addr_match.sv
module tws_addr_match
    import tws_pkg::*;
(
    input  logic [BYTE_W-1:0] pkt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              busy,
    output match_t            m
);
    logic [ADDR_W-1:0] addr;
    logic rw, gcall, rsvd, own_hit;

    always_comb begin
        addr    = pkt[BYTE_W-1:1];
        rw      = pkt[0];
        gcall   = (addr == '0);
        rsvd    = is_reserved(addr);
        own_hit = !gcall && !rsvd && (addr == own_addr);
        m.rd    = rw;
        m.gc    = gcall && !rw && gc_en;
        m.ack   = !busy && (m.gc || own_hit);
    end
endmodule

// File: rtl/tws_target.sv
module tws_target
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              gc_en,
    input  logic              busy,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_load,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sel,
    output logic              dir_rd,
    output logic              gen_call,
    output logic              ctl_nack
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    st_t               st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              ack_ok;
    match_t            m;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    tws_addr_match u_match (
        .pkt(sh), .own_addr(own_addr), .gc_en(gc_en), .busy(busy), .m(m)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cnt      <= '0;
            sh       <= '0;
            ack_ok   <= 1'b0;
            sda_oe   <= 1'b0;
            sel      <= 1'b0;
            dir_rd   <= 1'b0;
            gen_call <= 1'b0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            ctl_nack <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_load  <= 1'b0;
            ctl_nack <= 1'b0;
            if (start_c) begin
                st       <= S_ADDR;
                cnt      <= '0;
                sda_oe   <= 1'b0;
                sel      <= 1'b0;
                dir_rd   <= 1'b0;
                gen_call <= 1'b0;
            end else if (stop_c) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
                sel    <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_RX: if (scl_rise) begin
                        sh <= {sh[BYTE_W-2:0], sda_s};
                        if (cnt == LAST_BIT) begin
                            cnt <= '0;
                            st  <= (st == S_ADDR) ? S_AWAIT : S_RWAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_AWAIT: if (scl_fall) begin
                        if (m.ack) begin
                            sda_oe   <= 1'b1;
                            sel      <= 1'b1;
                            dir_rd   <= m.rd;
                            gen_call <= m.gc;
                            st       <= S_AACK;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                    S_AACK: if (scl_fall) begin
                        cnt <= '0;
                        if (dir_rd) begin
                            sh      <= tx_data;
                            sda_oe  <= ~tx_data[BYTE_W-1];
                            tx_load <= 1'b1;
                            st      <= S_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= S_RX;
                        end
                    end
                    S_RWAIT: if (scl_fall) begin
                        if (!busy) begin
                            rx_data  <= sh;
                            rx_valid <= 1'b1;
                            sda_oe   <= 1'b1;
                            st       <= S_RACK;
                        end else begin
                            sel <= 1'b0;
                            st  <= S_IDLE;
                        end
                    end
                    S_RACK: if (scl_fall) begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        st     <= S_RX;
                    end
                    S_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == ALL_BITS) begin
                                sda_oe <= 1'b0;
                                st     <= S_TACK;
                            end else begin
                                sh     <= sh << 1;
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    S_TACK: if (scl_rise) begin
                        ack_ok   <= ~sda_s;
                        ctl_nack <= sda_s;
                        st       <= S_TDONE;
                    end
                    S_TDONE: if (scl_fall) begin
                        cnt <= '0;
                        if (ack_ok) begin
                            sh      <= tx_data;
                            sda_oe  <= ~tx_data[BYTE_W-1];
                            tx_load <= 1'b1;
                            st      <= S_TX;
                        end else begin
                            sel <= 1'b0;
                            st  <= S_IDLE;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R11: the data line is only pulled while the clock is low
    p_drive_clock_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);
    // R9: reserved address group never acknowledged
    p_reserved_nack_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_AWAIT && scl_fall && is_reserved(sh[BYTE_W-1:1])) |=> !sda_oe);
    // R8: general call with read bit never acknowledged
    p_gc_read_nack_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_AWAIT && scl_fall && sh == {ADDR_W'(0), 1'b1}) |=> !sda_oe);
    // R10: busy forces NACK in any acknowledge slot
    p_busy_nack_r10: assert property (@(posedge clk) disable iff (rst)
        ((st == S_AWAIT || st == S_RWAIT) && scl_fall && busy) |=> (!sda_oe && !rx_valid));
    // R4: received bytes only reported in an addressed write transfer
    p_rx_write_only_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (sel && !dir_rd));
    // R2: STOP releases the line and deselects
    p_stop_release_r2: assert property (@(posedge clk) disable iff (rst)
        stop_c |=> (!sda_oe && !sel));
    // R6: controller NACK ends the read with the line released
    p_nack_release_r6: assert property (@(posedge clk) disable iff (rst)
        ctl_nack |-> !sda_oe);
endmodule

// File: tb/sim_tws_target.sv
module sim_tws_target;
    localparam int BW = 8;
    localparam int AW = 7;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_scl = 1'b1, ctl_sda = 1'b1;
    logic bus_sda;
    logic sda_oe, tx_load, rx_valid, sel, dir_rd, gen_call, ctl_nack;
    logic [AW-1:0] own_addr = 7'h3A;
    logic gc_en = 1'b0, busy = 1'b0;
    logic [BW-1:0] tx_data = '0;
    logic [BW-1:0] rx_data;

    int n_run = 0, n_fail = 0, n_load = 0;
    logic [BW-1:0] exp_q[$];

    always #10 clk = ~clk;
    assign bus_sda = ctl_sda & ~sda_oe;

    tws_target u0 (
        .clk(clk), .rst(rst), .scl_i(ctl_scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .own_addr(own_addr), .gc_en(gc_en), .busy(busy), .tx_data(tx_data),
        .tx_load(tx_load), .rx_data(rx_data), .rx_valid(rx_valid), .sel(sel),
        .dir_rd(dir_rd), .gen_call(gen_call), .ctl_nack(ctl_nack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask
    task automatic bus_start;
        ctl_sda = 1'b1; wq; ctl_scl = 1'b1; wq; ctl_sda = 1'b0; wq; ctl_scl = 1'b0; wq;
    endtask
    task automatic bus_stop;
        ctl_sda = 1'b0; wq; ctl_scl = 1'b1; wq; ctl_sda = 1'b1; wq;
    endtask
    task automatic put_bit(input logic b);
        ctl_sda = b; wq; ctl_scl = 1'b1; wq; wq; ctl_scl = 1'b0; wq;
    endtask
    task automatic get_bit(output logic b);
        ctl_sda = 1'b1; wq; ctl_scl = 1'b1; wq; b = bus_sda; wq; ctl_scl = 1'b0; wq;
    endtask
    task automatic put_byte(input logic [BW-1:0] v, output logic ack);
        logic a;
        for (int i = BW - 1; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask
    task automatic get_byte(output logic [BW-1:0] v, input logic ack);
        for (int i = BW - 1; i >= 0; i--) get_bit(v[i]);
        put_bit(!ack);
    endtask
    // driver: sends a data byte and, if it should be accepted, queues it for the monitor
    task automatic send_data(input logic [BW-1:0] v, input logic expect_ack, input string tag);
        logic a;
        if (expect_ack) exp_q.push_back(v);
        put_byte(v, a);
        chk(tag, int'(a), int'(expect_ack));
    endtask

    // monitor / scoreboard for received bytes (R4)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_load) n_load++;
            if (!rst && rx_valid) begin
                if (exp_q.size() == 0) chk("R4 unexpected rx byte", int'(rx_data), -1);
                else chk("R4 rx byte", int'(rx_data), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic a;
        logic [BW-1:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 sel", int'(sel), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 tx_load", int'(tx_load), 0);

        // R3 / R4: write to own address, two bytes
        bus_start;
        put_byte({7'h3A, 1'b0}, a);
        chk("R3 own addr ack", int'(a), 1);
        chk("R3 sel", int'(sel), 1);
        send_data(8'hA5, 1'b1, "R4 ack A5");
        send_data(8'h3C, 1'b1, "R4 ack 3C");
        bus_stop;
        wq;
        chk("R2 stop sel", int'(sel), 0);
        chk("R2 stop oe", int'(sda_oe), 0);

        // R3: other address not answered
        bus_start;
        put_byte({7'h3B, 1'b0}, a);
        chk("R3 wrong addr nack", int'(a), 0);
        bus_stop;

        // R5 / R6 / R11: read two bytes, NACK the second
        tx_data = 8'h96;
        bus_start;
        put_byte({7'h3A, 1'b1}, a);
        chk("R3 read addr ack", int'(a), 1);
        tx_data = 8'h5B;
        get_byte(v, 1'b1);
        chk("R5 byte1", int'(v), 'h96);
        chk("R11 sel held", int'(sel), 1);
        get_byte(v, 1'b0);
        chk("R5 byte2", int'(v), 'h5B);
        chk("R5 loads", n_load, 2);
        chk("R6 release oe", int'(sda_oe), 0);
        chk("R6 sel drop", int'(sel), 0);
        get_byte(v, 1'b0);
        chk("R6 silent", int'(v), 'hFF);
        bus_stop;

        // R7: general call enabled and disabled
        gc_en = 1'b1;
        bus_start;
        put_byte(8'h00, a);
        chk("R7 gc ack", int'(a), 1);
        chk("R7 gen_call", int'(gen_call), 1);
        send_data(8'h71, 1'b1, "R7 gc data");
        bus_stop;
        gc_en = 1'b0;
        bus_start;
        put_byte(8'h00, a);
        chk("R7 gc disabled nack", int'(a), 0);
        bus_stop;

        // R8: general call with read bit
        gc_en = 1'b1;
        tx_data = 8'h00;
        bus_start;
        put_byte(8'h01, a);
        chk("R8 gc read nack", int'(a), 0);
        get_byte(v, 1'b0);
        chk("R8 nothing driven", int'(v), 'hFF);
        bus_stop;
        gc_en = 1'b0;

        // R9: reserved group, even as own address
        own_addr = 7'h7A;
        bus_start;
        put_byte({7'h7A, 1'b0}, a);
        chk("R9 reserved nack", int'(a), 0);
        bus_stop;
        own_addr = 7'h3A;

        // R10: busy at address and at data
        busy = 1'b1;
        bus_start;
        put_byte({7'h3A, 1'b0}, a);
        chk("R10 busy addr nack", int'(a), 0);
        bus_stop;
        busy = 1'b0;
        bus_start;
        put_byte({7'h3A, 1'b0}, a);
        chk("R10 addr ack", int'(a), 1);
        send_data(8'h11, 1'b1, "R10 first byte ack");
        busy = 1'b1;
        send_data(8'h22, 1'b0, "R10 busy data nack");
        chk("R10 sel drop", int'(sel), 0);
        bus_stop;
        busy = 1'b0;

        // R2: repeated START mid-byte discards partial byte
        bus_start;
        put_byte({7'h3A, 1'b0}, a);
        chk("R2 addr ack", int'(a), 1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start;
        put_byte({7'h3A, 1'b0}, a);
        chk("R2 restart addr ack", int'(a), 1);
        send_data(8'hC3, 1'b1, "R2 data after restart");
        bus_stop;
        wq;

        chk("R4 queue drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule